// File: doc/BRIEF.md
# Single-Shot Converter Sequencer

This block lets software run one analog-to-digital conversion at a time through two 32-bit registers on a simple write/read register bus. A write to the control word picks one of eight inputs, sets a clock divider, chooses the reference source and can launch a conversion. The block then paces an external successive-approximation front end with a clock-enable pulse train, captures that input's sample, and moves a 10-bit code into the data word. It then raises an interrupt status flag, which drives an interrupt line when the interrupt is enabled.

The front end is modelled by a packed bus that carries the present 10-bit code for each input. The block reports the selected input and a one-cycle completion strobe. A module-reset bit in the control word gives software a way to recover from a conversion that never ends. Software then enables the converter again and starts a new conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, both the control word (address 0x0) and the data word (address 0x4) read as zero, and irq, refSel and convClkEn are low.
- R2: The control word stores the input select in bits 27:24, interrupt enable in bit 21, reference select in bit 19, converter enable in bit 17 and divider N in bits 8:1, and these fields read back exactly as written. The refSel output follows bit 19.
- R3: Writing bit 13 as 1 together with bit 17 as 1 starts a conversion. Bit 13 reads 1 from the cycle after the write and returns to 0 exactly 24*(N+1) clocks after the write edge.
- R4: While a conversion runs, convClkEn pulses for one clock every 2*(N+1) clocks. The first pulse comes 2*(N+1) clocks after the write edge, and there are exactly 12 pulses, the last coinciding with convDone.
- R5: A start request written with bit 17 equal to 0 is ignored. No pulse, no completion and no busy indication follow.
- R6: The data word bits 9:0 receive the code of the input named by bits 26:24 (bit 27 is ignored), as present on sampleBus at the first convClkEn pulse. Bits 31:10 read 0. The data word keeps its old value until completion and then changes in a single step.
- R7: Writes to the input select or divider while a conversion runs are stored in the control word, but the running conversion keeps the input and divider captured at its start.
- R8: Completion sets bit 18. Writing the control word with bit 18 as 1 clears it, and writing it with bit 18 as 0 leaves it set.
- R9: irq is high exactly when bit 18 and bit 21 are both set.
- R10: Writing bit 16 as 1 clears every control field, the status flag and the data word, and aborts a running conversion with no completion. Bit 16 reads 0. A later enable and start runs normally.
- R11: A start request written while a conversion runs is ignored and does not restart or lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| sampleBus | input | NUM_CH*RES_W | Present code of every input, input k in bits k*10 upward |
| convClkEn | output | 1 | One-cycle converter clock enable |
| convChan | output | CH_W | Input captured for the running conversion |
| convDone | output | 1 | One-cycle completion strobe |
| irq | output | 1 | Interrupt request |
| refSel | output | 1 | High selects the internal reference |

## Verification
The bench counts the exact conversion length and the spacing of every converter pulse for the smallest and largest divider. An off-by-one in the divider compare, or a pacing that uses N+1 instead of 2*(N+1), would show up as a wrong duration or spacing. It changes the selected input's code after the sample pulse and rewrites the input select, the divider and the start bit mid-conversion. A design that samples late, tracks live configuration or restarts would return the new code or finish at the wrong cycle. It also issues a start with the converter disabled, aborts a long conversion with the module-reset bit, and clears the status flag with both values of bit 18. A stray completion, a surviving data word or status flag, or a write-anything-to-clear flag would each be reported.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int NUM_CH       = 8;
  localparam int CH_W         = $clog2(NUM_CH);
  localparam int CHAN_FIELD_W = 4;
  localparam int RES_W        = 10;
  localparam int DIV_W        = 8;
  localparam int CONV_PERIODS = 12;
  localparam int PER_W        = $clog2(CONV_PERIODS);
  localparam int DATA_W       = 32;

  localparam int CTRL_OFS = 0;
  localparam int DATA_OFS = 4;

  localparam int B_CHAN_LO = 24;
  localparam int B_INT_EN  = 21;
  localparam int B_REF_SEL = 19;
  localparam int B_INT_ST  = 18;
  localparam int B_CONV_EN = 17;
  localparam int B_MOD_RST = 16;
  localparam int B_START   = 13;
  localparam int B_DIV_LO  = 1;

  typedef struct packed {
    logic            start;
    logic            abort;
    logic [CH_W-1:0] chan;
    logic [DIV_W-1:0] div;
  } convCmd_t;
endpackage

// File: rtl/sar_conv_datapath.sv
module sar_conv_datapath
  import sar_conv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  convCmd_t                 cmd,
  input  logic [NUM_CH*RES_W-1:0]  sampleBus,
  output logic                     running,
  output logic                     tick,
  output logic                     done,
  output logic [CH_W-1:0]          chanSel,
  output logic [RES_W-1:0]         result
);
  localparam int CNT_W = DIV_W + 1;

  logic [RES_W-1:0] chanSample [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gSlice
      assign chanSample[g] = sampleBus[g*RES_W +: RES_W];
    end
  endgenerate

  logic              runQ;
  logic [DIV_W-1:0]  divQ;
  logic [CH_W-1:0]   chanQ;
  logic [CNT_W-1:0]  divCnt;
  logic [PER_W-1:0]  perCnt;
  logic [RES_W-1:0]  holdQ;
  logic [RES_W-1:0]  resultQ;
  logic [CNT_W-1:0]  divLast;
  logic              sampleEdge;

  // one converter clock spans 2*(N+1) input clocks: count 0 .. 2N+1
  assign divLast    = {divQ, 1'b1};
  assign tick       = runQ && (divCnt == divLast);
  assign done       = tick && (perCnt == PER_W'(CONV_PERIODS - 1));
  assign sampleEdge = tick && (perCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      divQ    <= '0;
      chanQ   <= '0;
      divCnt  <= '0;
      perCnt  <= '0;
      holdQ   <= '0;
      resultQ <= '0;
    end else if (cmd.abort) begin
      runQ    <= 1'b0;
      divQ    <= '0;
      chanQ   <= '0;
      divCnt  <= '0;
      perCnt  <= '0;
      holdQ   <= '0;
      resultQ <= '0;
    end else if (!runQ) begin
      if (cmd.start) begin
        runQ   <= 1'b1;
        divQ   <= cmd.div;
        chanQ  <= cmd.chan;
        divCnt <= '0;
        perCnt <= '0;
      end
    end else if (tick) begin
      divCnt <= '0;
      perCnt <= perCnt + 1'b1;
      if (sampleEdge) holdQ <= chanSample[chanQ];
      if (done) begin
        runQ    <= 1'b0;
        resultQ <= holdQ;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign running = runQ;
  assign chanSel = chanQ;
  assign result  = resultQ;

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !runQ && !cmd.abort) |=> (runQ && perCnt == '0 && divCnt == '0));

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !cmd.abort) |=> $stable(resultQ));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !done && !cmd.abort) |=> ($stable(chanQ) && $stable(divQ)));

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.abort |=> (!runQ && resultQ == '0));
endmodule

// File: rtl/sar_conv_regs.sv
module sar_conv_regs
  import sar_conv_pkg::*;
#(
  parameter int ADDR_W = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               running,
  input  logic               done,
  input  logic [RES_W-1:0]   result,
  output convCmd_t           cmd,
  output logic               irq,
  output logic               refSel
);
  logic [CHAN_FIELD_W-1:0] chanF;
  logic [DIV_W-1:0]        divF;
  logic                    intEnF;
  logic                    refSelF;
  logic                    intStF;
  logic                    enF;

  logic wrCtrl;
  logic modRst;
  logic selCtrl;
  logic selData;

  assign selCtrl = (regAddr == ADDR_W'(CTRL_OFS));
  assign selData = (regAddr == ADDR_W'(DATA_OFS));
  assign wrCtrl  = regWe && selCtrl;
  assign modRst  = wrCtrl && regWdata[B_MOD_RST];

  always_comb begin
    cmd.abort = modRst;
    cmd.start = wrCtrl && !modRst && regWdata[B_START] && regWdata[B_CONV_EN] && !running;
    cmd.chan  = regWdata[B_CHAN_LO +: CH_W];
    cmd.div   = regWdata[B_DIV_LO +: DIV_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanF   <= '0;
      divF    <= '0;
      intEnF  <= 1'b0;
      refSelF <= 1'b0;
      intStF  <= 1'b0;
      enF     <= 1'b0;
    end else if (modRst) begin
      chanF   <= '0;
      divF    <= '0;
      intEnF  <= 1'b0;
      refSelF <= 1'b0;
      intStF  <= 1'b0;
      enF     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        chanF   <= regWdata[B_CHAN_LO +: CHAN_FIELD_W];
        divF    <= regWdata[B_DIV_LO +: DIV_W];
        intEnF  <= regWdata[B_INT_EN];
        refSelF <= regWdata[B_REF_SEL];
        enF     <= regWdata[B_CONV_EN];
      end
      if (done)
        intStF <= 1'b1;
      else if (wrCtrl && regWdata[B_INT_ST])
        intStF <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (selCtrl) begin
      regRdata[B_CHAN_LO +: CHAN_FIELD_W] = chanF;
      regRdata[B_INT_EN]                  = intEnF;
      regRdata[B_REF_SEL]                 = refSelF;
      regRdata[B_INT_ST]                  = intStF;
      regRdata[B_CONV_EN]                 = enF;
      regRdata[B_START]                   = running;
      regRdata[B_DIV_LO +: DIV_W]         = divF;
    end else if (selData) begin
      regRdata[RES_W-1:0] = result;
    end
  end

  assign irq    = intStF && intEnF;
  assign refSel = refSelF;

  logic unusedWr;
  assign unusedWr = ^regWdata;

  // R8
  int_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modRst) |=> intStF);

  // R8
  int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !modRst && regWdata[B_INT_ST] && !done) |=> !intStF);

  // R10
  mod_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    modRst |=> (!intStF && !enF && chanF == '0 && divF == '0 && !irq));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int ADDR_W = 4
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  input  logic [NUM_CH*RES_W-1:0]  sampleBus,
  output logic                     convClkEn,
  output logic [CH_W-1:0]          convChan,
  output logic                     convDone,
  output logic                     irq,
  output logic                     refSel
);
  convCmd_t         cmd;
  logic             running;
  logic             tick;
  logic             done;
  logic [RES_W-1:0] result;

  sar_conv_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .running  (running),
    .done     (done),
    .result   (result),
    .cmd      (cmd),
    .irq      (irq),
    .refSel   (refSel)
  );

  sar_conv_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .sampleBus (sampleBus),
    .running   (running),
    .tick      (tick),
    .done      (done),
    .chanSel   (convChan),
    .result    (result)
  );

  assign convClkEn = tick;
  assign convDone  = done;
endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  import sar_conv_pkg::*;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic                    regWe;
  logic [ADDR_W-1:0]       regAddr;
  logic [31:0]             regWdata;
  logic [31:0]             regRdata;
  logic [NUM_CH*RES_W-1:0] sampleBus;
  logic                    convClkEn;
  logic [CH_W-1:0]         convChan;
  logic                    convDone;
  logic                    irq;
  logic                    refSel;
  logic [9:0]              samp [8];

  always_comb
    for (int c = 0; c < 8; c++) sampleBus[c*10 +: 10] = samp[c];

  sar_conv_ctrl u_sar_conv_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sampleBus(sampleBus),
    .convClkEn(convClkEn), .convChan(convChan), .convDone(convDone),
    .irq(irq), .refSel(refSel)
  );

  int checks = 0, errors = 0, cyc = 0;
  int startCyc = 0, curP = 2, tickCnt = 0, lastTick = 0, doneCount = 0;
  bit pend = 0;
  logic [31:0] pendExp, lastData;
  logic [31:0] expQ [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(int ch, bit ie, bit rs, bit ist, bit en,
                                         bit mr, bit st, int dv);
    logic [31:0] w;
    w = '0;
    w[27:24] = ch[3:0];
    w[21] = ie; w[19] = rs; w[18] = ist; w[17] = en; w[16] = mr; w[13] = st;
    w[8:1] = dv[7:0];
    return w;
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'h0; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = 4'h4;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
    #1 regAddr = 4'h4;
  endtask

  // monitor: pops expected items at completion and compares timing and data
  always @(negedge clk) begin
    if (rstN) begin
      if (pend) begin
        chk(regRdata == pendExp, "R6 result word", regRdata, pendExp);
        pend = 0;
        doneCount++;
      end
      if (convClkEn) begin
        if (tickCnt == 0) chk(cyc - startCyc == curP - 1, "R4 first pulse", cyc - startCyc, curP - 1);
        else              chk(cyc - lastTick == curP, "R4 pulse spacing", cyc - lastTick, curP);
        tickCnt++;
        lastTick = cyc;
      end
      if (convDone) begin
        if (expQ.size() == 0) chk(1'b0, "R5 R10 unexpected completion", 1, 0);
        else begin
          pendExp = expQ.pop_front();
          pend = 1;
          chk(tickCnt == 12, "R4 pulse count", tickCnt, 12);
          chk(cyc - startCyc == 12*curP - 1, "R3 conversion length", cyc - startCyc, 12*curP - 1);
        end
      end
    end
  end

  task automatic runConv(int ch, int dv, bit ie, bit midWrite);
    logic [31:0] v, e;
    int n;
    n = doneCount;
    curP = 2*(dv + 1);
    tickCnt = 0;
    e = {22'b0, samp[ch & 7]};
    expQ.push_back(e);
    wr(mkCtrl(ch, ie, 0, 0, 1, 0, 1, dv));
    startCyc = cyc;
    rd(4'h0, v);
    chk(v[13] == 1'b1, "R3 busy bit set", 32'(v[13]), 1);
    rd(4'h4, v);
    chk(v == lastData, "R6 data word held during conversion", v, lastData);
    repeat (curP) @(negedge clk);
    samp[ch & 7] = ~samp[ch & 7];
    // R7 R11: new select, new divider and a second start mid-conversion
    if (midWrite) wr(mkCtrl((ch + 3) % 8, ie, 0, 0, 1, 0, 1, dv + 5));
    wait (doneCount == n + 1);
    lastData = e;
    rd(4'h0, v);
    chk(v[13] == 1'b0, "R3 busy bit cleared", 32'(v[13]), 0);
  endtask

  initial begin
    logic [31:0] v, w;
    regWe = 0; regAddr = 4'h4; regWdata = '0; lastData = '0;
    for (int c = 0; c < 8; c++) samp[c] = 10'(c*97 + 13);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, v); chk(v == 0, "R1 control word", v, 0);
    rd(4'h4, v); chk(v == 0, "R1 data word", v, 0);
    chk({irq, refSel, convClkEn} == 3'b000, "R1 outputs low", {irq, refSel, convClkEn}, 0);

    // R2 field readback, bit 27 included
    w = mkCtrl(13, 1, 1, 0, 0, 0, 0, 8'hA5);
    wr(w);
    rd(4'h0, v); chk(v == w, "R2 readback", v, w);
    chk(refSel == 1'b1, "R2 refSel output", refSel, 1);

    // R5 start with converter disabled
    wr(mkCtrl(2, 1, 1, 0, 0, 0, 1, 0));
    rd(4'h0, v); chk(v[13] == 1'b0, "R5 no busy", 32'(v[13]), 0);
    repeat (40) @(negedge clk);
    chk(irq == 1'b0, "R5 no interrupt", irq, 0);
    rd(4'h4, v); chk(v == 0, "R5 data unchanged", v, 0);

    // smallest divider, interrupt enabled
    runConv(3, 0, 1, 0);
    rd(4'h0, v); chk(v[18] == 1'b1, "R8 status set", 32'(v[18]), 1);
    chk(irq == 1'b1, "R9 irq with enable", irq, 1);
    w = v; w[18] = 1'b0;
    wr(w);
    rd(4'h0, v); chk(v[18] == 1'b1, "R8 write 0 keeps status", 32'(v[18]), 1);
    w[18] = 1'b1;
    wr(w);
    rd(4'h0, v); chk(v[18] == 1'b0, "R8 write 1 clears status", 32'(v[18]), 0);
    chk(irq == 1'b0, "R9 irq after clear", irq, 0);

    // R7 R11 mid-conversion writes, interrupt disabled
    runConv(6, 3, 0, 1);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    rd(4'h0, v);
    chk(v[18] == 1'b1, "R8 status without enable", 32'(v[18]), 1);
    chk(v[27:24] == 4'd1, "R7 new select stored", 32'(v[27:24]), 1);
    chk(v[8:1] == 8'd8, "R7 new divider stored", 32'(v[8:1]), 8);

    // largest divider, top input
    runConv(7, 255, 1, 0);
    // select with bit 27 set uses input 4
    runConv(12, 1, 1, 0);

    // R10 abort with module reset
    curP = 22; tickCnt = 0;
    wr(mkCtrl(1, 1, 0, 0, 1, 0, 1, 10));
    startCyc = cyc;
    repeat (15) @(negedge clk);
    wr(mkCtrl(3, 1, 1, 0, 1, 1, 0, 9));
    rd(4'h0, v); chk(v == 0, "R10 control cleared", v, 0);
    rd(4'h4, v); chk(v == 0, "R10 data cleared", v, 0);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
    repeat (300) @(negedge clk);
    chk(convClkEn == 1'b0, "R10 pacing stopped", convClkEn, 0);
    lastData = '0;
    // R10 recovery: enable and restart
    runConv(0, 2, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule